// File: doc/BRIEF.md
# Zero-Fill Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream. It is a chain of flip-flops. The first stage takes a constant zero as its data input, and the serial output is taken from the last stage.

A word is placed into the chain by a load pulse rather than by a clock edge. While the load pulse is high, it asynchronously forces to 1 every stage whose matching parallel bit is 1. It never clears a stage. For this reason the chain must be empty before a word is loaded. After a reset it is empty. It is also empty after the previous word has been fully shifted out, because zeros enter at the head on every clock.

An external controller is expected to run the sequence: reset, present the word, pulse load, then give one clock per bit. The first bit is visible at the serial output as soon as the load pulse has been applied, before any clock edge.

Top module: `zfp_piso`

## Requirements
- R1: A high `rst` asynchronously forces every stage (`stage_q`) to 0.
- R2: While `load` is high, each stage whose mapped `par_in` bit is 1 is set to 1 without waiting for a clock. A stage whose mapped bit is 0 keeps its current value, so loading onto leftover contents gives the OR of the old and new bits.
- R3: For a chain of WIDTH stages, stage k (`stage_q[k]`) is set by `par_in[WIDTH-1-k]`. Stage 0 is the head and stage WIDTH-1 is the tail.
- R4: On each rising `clk` edge with `rst` and `load` low, stage k (k>0) takes the value stage k-1 held before the edge.
- R5: On each rising `clk` edge with `rst` and `load` low, stage 0 takes 0.
- R6: `sout` equals the tail stage. After a load into an empty chain it shows `par_in[0]`, then `par_in[1]`, and so on up to `par_in[WIDTH-1]`, one bit per clock.
- R7: After WIDTH clocks following a load, every stage is 0, and a new word can be loaded without a reset.
- R8: When `rst` and `load` are high together, all stages stay 0.
- R9: If `load` is still high at a clock edge, any stage whose mapped bit is 1 stays 1. The other stages shift normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Asynchronous clear, active high |
| load | input | 1 | Asynchronous set enable, active high |
| par_in | input | WIDTH | Parallel word to be loaded |
| sout | output | 1 | Serial output (tail stage) |
| stage_q | output | WIDTH | Contents of every stage, bit k is stage k |

## Verification
The bench builds the block with its default WIDTH of 4. At that width, a complete word drains in four clocks, so each burst can be followed from the load through to the empty chain. With a short chain, every OR of leftover bits with a new word can be stated exactly. The same holds for the case where `load` is held across a clock edge and the set bit meets a shifted bit. The bit-order mapping of R3 and R6 is checked with words that are not symmetric, so a reversed mapping would be caught.

// File: rtl/zfp_pkg.sv
package zfp_pkg;

   localparam int MIN_WIDTH = 2;

   // Parallel bit index that drives the asynchronous set of a given stage.
   function automatic int set_source(input int stage, input int width);
      return width - 1 - stage;
   endfunction

endpackage

// File: rtl/zfp_set_map.sv
module zfp_set_map #(
   parameter int WIDTH = 4
) (
   input  logic             load,
   input  logic [WIDTH-1:0] par_in,
   output logic [WIDTH-1:0] set_o
);
   import zfp_pkg::*;

   for (genvar k = 0; k < WIDTH; k++) begin : g_map
      localparam int SRC = set_source(k, WIDTH);
      assign set_o[k] = load & par_in[SRC];
   end

endmodule

// File: rtl/zfp_stage.sv
module zfp_stage (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic d_i,
   output logic q_o
);

   always_ff @(posedge clk or posedge rst or posedge set_i) begin
      if (rst)        q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else            q_o <= d_i;
   end

   AST_SET_HOLDS_ONE: assert property (@(posedge clk) disable iff (rst)
      set_i |-> q_o); // R9

endmodule

// File: rtl/zfp_chain.sv
module zfp_chain #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] set_i,
   output logic [WIDTH-1:0] q_o
);

   localparam logic FILL = 1'b0;

   logic [WIDTH-1:0] d_w;

   assign d_w[0] = FILL;

   for (genvar k = 1; k < WIDTH; k++) begin : g_link
      assign d_w[k] = q_o[k-1];
   end

   for (genvar k = 0; k < WIDTH; k++) begin : g_stage
      zfp_stage u_stage (
         .clk   (clk),
         .rst   (rst),
         .set_i (set_i[k]),
         .d_i   (d_w[k]),
         .q_o   (q_o[k])
      );
   end

   // Records that load was high at some point since the last clock edge.
   // The assertions use it to excuse cycles in which a set occurred.
   logic load_seen;
   always_ff @(posedge clk or posedge rst or posedge load) begin
      if (rst)       load_seen <= 1'b0;
      else if (load) load_seen <= 1'b1;
      else           load_seen <= 1'b0;
   end

   AST_HEAD_TAKES_ZERO: assert property (@(posedge clk) disable iff (rst)
      !load |=> (load_seen || q_o[0] == 1'b0)); // R5

   for (genvar k = 1; k < WIDTH; k++) begin : g_chk
      AST_STAGE_SHIFTS: assert property (@(posedge clk) disable iff (rst)
         !load |=> (load_seen || q_o[k] == $past(q_o[k-1]))); // R4
   end

   AST_EMPTY_STAYS_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (q_o == '0 && !load) |=> (load_seen || q_o == '0)); // R7

endmodule

// File: rtl/zfp_piso.sv
module zfp_piso #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] par_in,
   output logic             sout,
   output logic [WIDTH-1:0] stage_q
);
   import zfp_pkg::*;

   localparam int TAIL = WIDTH - 1;

   if (WIDTH < MIN_WIDTH) begin : g_bad_width
      $error("zfp_piso: WIDTH must be at least MIN_WIDTH");
   end

   logic [WIDTH-1:0] set_w;

   zfp_set_map #(.WIDTH(WIDTH)) u_map (
      .load   (load),
      .par_in (par_in),
      .set_o  (set_w)
   );

   zfp_chain #(.WIDTH(WIDTH)) u_chain (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .set_i (set_w),
      .q_o   (stage_q)
   );

   assign sout = stage_q[TAIL];

endmodule

// File: tb/zfp_piso_bench.sv
module zfp_piso_bench;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load = 1'b0;
   logic [W-1:0] par_in = '0;
   logic         sout;
   logic [W-1:0] stage_q;

   int checks = 0;
   int errors = 0;
   bit exp_q[$];
   string exp_tag[$];
   logic [W-1:0] m;

   zfp_piso #(.WIDTH(W)) u_zfp_piso (
      .clk(clk), .rst(rst), .load(load), .par_in(par_in),
      .sout(sout), .stage_q(stage_q)
   );

   always #4 clk = ~clk;

   function automatic logic [W-1:0] rev(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: compares the serial output once per cycle against the queue.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         bit e;
         string t;
         e = exp_q.pop_front();
         t = exp_tag.pop_front();
         chk(t, {31'b0, sout}, {31'b0, e});
      end
   end

   // Driver: pulses load just after an edge and queues the expected stream.
   task automatic burst(input logic [W-1:0] word);
      @(posedge clk); #1;
      par_in = word; load = 1'b1; #1; load = 1'b0;
      chk("R3", stage_q, rev(word));
      for (int i = 0; i < W; i++) begin
         exp_q.push_back(word[i]); exp_tag.push_back("R6");
      end
      exp_q.push_back(1'b0); exp_tag.push_back("R7");
      wait (exp_q.size() == 0);
      #1 chk("R7", stage_q, '0);
   endtask

   initial begin
      #(8 * 20000);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1 chk("R1", stage_q, '0);
      @(posedge clk); @(posedge clk); #1 rst = 1'b0;

      burst(4'b0110);
      burst(4'b1001);   // no reset in between: R7

      // Leftover contents ORed with a new word
      @(posedge clk); #1;
      par_in = 4'b1010; load = 1'b1; #1; load = 1'b0;
      m = rev(4'b1010);
      @(posedge clk); #1;
      m = {m[W-2:0], 1'b0};
      chk("R4/R5 shift", stage_q, m);
      par_in = 4'b0011; load = 1'b1; #1; load = 1'b0;
      m = m | rev(4'b0011);
      chk("R2", stage_q, m);
      rst = 1'b1; #1 chk("R1", stage_q, '0);
      @(posedge clk); #1 rst = 1'b0;

      // Reset wins over load
      @(posedge clk); #1;
      rst = 1'b1; par_in = 4'b1111; load = 1'b1; #1;
      chk("R8", stage_q, '0);
      load = 1'b0; #1 rst = 1'b0; #1;
      chk("R8", stage_q, '0);

      // Load held across an edge
      @(posedge clk); #1;
      par_in = 4'b1000; load = 1'b1;
      m = rev(4'b1000);
      @(posedge clk); #1;
      m = {m[W-2:0], 1'b0} | rev(4'b1000);
      chk("R9", stage_q, m);
      load = 1'b0;
      for (int i = 0; i < W; i++) @(posedge clk);
      #1 chk("R5", stage_q, '0);

      burst(4'b1011);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule